// File: doc/BRIEF.md
# Dual-Format Stereo Audio Serial Port

This block is a full-duplex stereo audio serial port that sits between a simple host-side FIFO interface and an external audio codec. Software or a DMA engine pushes packed left/right sample pairs into a transmit FIFO. The block shifts each pair out on a serial data pin and, at the same time, shifts record samples in from the codec on a separate pin into a receive FIFO. It generates the bit clock and the left/right frame signal, and it can also drive an optional system clock to the codec.

A control bit selects one of two framings: standard I2S, where the sample MSB trails the left/right transition by one bit clock, or MSB-justified, where the MSB lines up with the transition. The bit clock comes from one of two sources. It is either divided down from the system clock by a programmable half-period count or taken from an external pin. Service request outputs follow the FIFO fill levels against programmable thresholds, so a DMA engine can be paced by them. Programmed I/O uses the same write and read strobes. Sticky underrun and overrun flags record FIFO starvation and loss, and each is cleared by a one-cycle clear pulse.

All logic runs on the system clock. The serial pins are registered outputs that change only on internal bit-clock strobes.

Top module: `stereo_serial_port`

## Requirements
- R1: Each frame is 64 bit clocks. `lrClk` is low for the left slot and high for the right slot. Each 32-bit slot carries a 16-bit sample, MSB first, and the remaining 16 bit positions are driven as zero.
- R2: With `fmtMsbJust`=0 (standard I2S), the sample MSB is in the bit-clock period after the `lrClk` transition. With `fmtMsbJust`=1, the MSB is in the same period as the transition.
- R3: `sdOut` and `lrClk` change only together with a falling edge of `bitClk`. `sdIn` is captured on the rising edge using the same slot layout and format as transmit, so a loopback returns each transmitted pair.
- R4: With `clkSrcExt`=0, `bitClk` is high for `divHalf`+1 system clocks and low for `divHalf`+1 system clocks. With `clkSrcExt`=1, `bitClk` follows `extBitClk` after a two-flop synchronizer, with the same period.
- R5: The FIFOs are 16 entries each. An entry packs the left sample in bits 31:16 and the right sample in bits 15:0. Pairs are sent and received in first-in, first-out order.
- R6: While enabled, `txReq` is high when the transmit fill level is at or below `txThresh`, and `rxReq` is high when the receive fill level is at or above `rxThresh`. Both are low while disabled.
- R7: At a frame start with the transmit FIFO empty, the frame carries zeros and `underrunFlag` sets. The flag stays set until a `clrUnderrun` pulse, and a new underrun takes priority over a clear.
- R8: When a received pair completes with the receive FIFO full, the pair is discarded, the 16 stored entries are kept, and `overrunFlag` sets. The flag stays set until a `clrOverrun` pulse.
- R9: While `enable` is low, `bitClk`, `lrClk`, `sdOut` and `sysClkOut` are low, both FIFOs are empty, and writes are ignored. Enabling starts a frame with the left slot at the first falling edge of `bitClk`.
- R10: While enabled, `sysClkOut` toggles on every system clock, giving half the system clock rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the divider reference |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Link enable; low flushes and idles the block |
| fmtMsbJust | input | 1 | 1 = MSB-justified framing, 0 = standard I2S |
| clkSrcExt | input | 1 | 1 = bit clock from `extBitClk`, 0 = internal divider |
| divHalf | input | DIV_W | Internal bit-clock half period minus one, in system clocks |
| txThresh | input | LVL_W | Transmit request threshold |
| rxThresh | input | LVL_W | Receive request threshold |
| txWrEn | input | 1 | Push `txWrData` into the transmit FIFO |
| txWrData | input | 32 | Packed left/right pair to send |
| txFull | output | 1 | Transmit FIFO full |
| rxRdEn | input | 1 | Pop the receive FIFO head |
| rxRdData | output | 32 | Receive FIFO head (show-ahead) |
| rxEmpty | output | 1 | Receive FIFO empty |
| txReq | output | 1 | Transmit service request |
| rxReq | output | 1 | Receive service request |
| underrunFlag | output | 1 | Sticky transmit underrun |
| clrUnderrun | input | 1 | Clear pulse for `underrunFlag` |
| overrunFlag | output | 1 | Sticky receive overrun |
| clrOverrun | input | 1 | Clear pulse for `overrunFlag` |
| extBitClk | input | 1 | External bit clock source |
| bitClk | output | 1 | Bit clock to the codec |
| lrClk | output | 1 | Left/right frame signal |
| sdOut | output | 1 | Serial playback data |
| sdIn | input | 1 | Serial record data |
| sysClkOut | output | 1 | Optional codec system clock |

## Verification
The assertions assume three things about the inputs:
- `fmtMsbJust`, `clkSrcExt` and `divHalf` change only while `enable` is low.
- An external bit clock stays in each level for several system clocks.
- When external clocking is enabled, the synchronized input is not in the middle of an edge.

The stimulus changes mode inputs only between disabled phases. It drives `extBitClk` with a four-clock half period, and it raises `enable` right after the external clock's low phase has settled. Clear pulses and manual receive reads are placed just after a left/right transition, so no frame-start load or receive push can coincide with them.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  // Slot geometry is fixed: 64 bit clocks per frame, 16-bit samples.
  localparam int SAMPLE_W = 16;
  localparam int PAIR_W   = 2 * SAMPLE_W;

  typedef struct packed {
    logic       drive;     // falling bit-clock strobe: update outputs
    logic       sample;    // rising bit-clock strobe: capture sdIn
    logic       loadTx;    // first drive of a frame: fetch a new pair
    logic       pushRx;    // sample strobe of the final right-channel bit
    logic       bitValid;  // current position carries sample data
    logic [4:0] bitSel;    // bit index into the packed pair
  } stb_t;
endpackage

// File: rtl/ssp_ctrl.sv
module ssp_ctrl
  import ssp_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             fmtMsbJust,
  input  logic             clkSrcExt,
  input  logic [DIV_W-1:0] divHalf,
  input  logic             extBitClk,
  output stb_t             stb,
  output logic             bitClkOut,
  output logic             lrClk,
  output logic             sysClkOut
);
  logic [1:0]       extSync;
  logic             extPrev;
  logic [DIV_W-1:0] divCnt;
  logic [5:0]       pos;
  logic             started;
  logic             intToggle, riseEv, fallEv;
  logic [5:0]       nextPos, curPos, dataPos;

  always_comb begin
    intToggle = !clkSrcExt && (divCnt == divHalf);
    riseEv    = clkSrcExt ? (extSync[1] & ~extPrev) : (intToggle & ~bitClkOut);
    fallEv    = clkSrcExt ? (~extSync[1] & extPrev) : (intToggle & bitClkOut);
    nextPos   = pos + 6'd1;
    stb.drive  = enable & fallEv;
    stb.sample = enable & riseEv & started;
    curPos    = stb.drive ? nextPos : pos;
    // standard I2S delays the data one bit behind the frame position
    dataPos   = fmtMsbJust ? curPos : (curPos - 6'd1);
    stb.bitValid = !dataPos[4];
    stb.bitSel   = {~dataPos[5], ~dataPos[3:0]};
    stb.loadTx   = stb.drive && (nextPos == 6'd0);
    stb.pushRx   = stb.sample && (dataPos == 6'd47);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extSync <= '0;
      extPrev <= 1'b0;
    end else begin
      extSync <= {extSync[0], extBitClk};
      extPrev <= extSync[1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0; bitClkOut <= 1'b0; pos <= 6'd63;
      started <= 1'b0; lrClk <= 1'b0; sysClkOut <= 1'b0;
    end else if (!enable) begin
      divCnt <= '0; bitClkOut <= 1'b0; pos <= 6'd63;
      started <= 1'b0; lrClk <= 1'b0; sysClkOut <= 1'b0;
    end else begin
      sysClkOut <= ~sysClkOut;
      if (clkSrcExt) begin
        bitClkOut <= extSync[1];
      end else if (intToggle) begin
        bitClkOut <= ~bitClkOut;
        divCnt    <= '0;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
      if (stb.drive) begin
        pos     <= nextPos;
        lrClk   <= nextPos[5];
        started <= 1'b1;
      end
    end
  end

  // R9: pins idle low one cycle after the link is disabled
  assert_idle_pins_low_R9: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!bitClkOut && !lrClk && !sysClkOut));

  // R3: the frame signal moves only with a falling bit clock
  assert_lr_on_fall_R3: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !$stable(lrClk)) |-> $fell(bitClkOut));

  // R10: codec system clock toggles every cycle once running
  assert_sysclk_toggle_R10: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $past(enable)) |-> !$stable(sysClkOut));
endmodule

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             empty,
  output logic             full,
  output logic [LW-1:0]    level
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic             doPush, doPop;

  assign empty  = (level == '0);
  assign full   = (level == LW'(DEPTH));
  assign doPush = push && !full && !flush;
  assign doPop  = pop && !empty && !flush;
  assign rdata  = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= wdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0; rdPtr <= '0; level <= '0;
    end else if (flush) begin
      wrPtr <= '0; rdPtr <= '0; level <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
      level <= level + LW'(doPush) - LW'(doPop);
    end
  end

  // R5: fill level never exceeds the configured depth
  assert_level_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    level <= LW'(DEPTH));

  // R8: a push into a full FIFO leaves the level unchanged
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    (full && push && !pop && !flush) |=> full);
endmodule

// File: rtl/ssp_datapath.sv
module ssp_datapath
  import ssp_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  localparam int LW = $clog2(FIFO_DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  stb_t              stb,
  input  logic [LW-1:0]     txThresh,
  input  logic [LW-1:0]     rxThresh,
  input  logic              txWrEn,
  input  logic [PAIR_W-1:0] txWrData,
  output logic              txFull,
  input  logic              rxRdEn,
  output logic [PAIR_W-1:0] rxRdData,
  output logic              rxEmpty,
  output logic              txReq,
  output logic              rxReq,
  output logic              underrunFlag,
  input  logic              clrUnderrun,
  output logic              overrunFlag,
  input  logic              clrOverrun,
  input  logic              sdIn,
  output logic              sdOut
);
  logic [PAIR_W-1:0] txHead, txPair, newPair, rxAsm, rxNext;
  logic              txEmpty, rxFull;
  logic [LW-1:0]     txLevel, rxLevel;

  ssp_fifo #(.WIDTH(PAIR_W), .DEPTH(FIFO_DEPTH)) u_txFifo (
    .clk(clk), .rstN(rstN), .flush(!enable),
    .push(txWrEn), .wdata(txWrData),
    .pop(stb.loadTx), .rdata(txHead),
    .empty(txEmpty), .full(txFull), .level(txLevel));

  ssp_fifo #(.WIDTH(PAIR_W), .DEPTH(FIFO_DEPTH)) u_rxFifo (
    .clk(clk), .rstN(rstN), .flush(!enable),
    .push(stb.pushRx), .wdata(rxNext),
    .pop(rxRdEn), .rdata(rxRdData),
    .empty(rxEmpty), .full(rxFull), .level(rxLevel));

  always_comb begin
    newPair = txPair;
    if (stb.loadTx) newPair = txEmpty ? '0 : txHead;
    rxNext = rxAsm;
    if (stb.sample && stb.bitValid) rxNext[stb.bitSel] = sdIn;
  end

  assign txReq = enable && (txLevel <= txThresh);
  assign rxReq = enable && (rxLevel >= rxThresh);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txPair <= '0; sdOut <= 1'b0; rxAsm <= '0;
    end else if (!enable) begin
      txPair <= '0; sdOut <= 1'b0; rxAsm <= '0;
    end else begin
      if (stb.drive) begin
        txPair <= newPair;
        sdOut  <= stb.bitValid ? newPair[stb.bitSel] : 1'b0;
      end
      rxAsm <= rxNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      underrunFlag <= 1'b0;
      overrunFlag  <= 1'b0;
    end else begin
      if (stb.loadTx && txEmpty) underrunFlag <= 1'b1;
      else if (clrUnderrun)      underrunFlag <= 1'b0;
      if (stb.pushRx && rxFull)  overrunFlag  <= 1'b1;
      else if (clrOverrun)       overrunFlag  <= 1'b0;
    end
  end

  // R3: serial output changes only after a falling-edge strobe
  assert_sd_on_fall_R3: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !$stable(sdOut)) |-> $past(stb.drive));

  // R7: starved frame start raises the sticky underrun flag
  assert_underrun_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.loadTx && txEmpty) |=> underrunFlag);

  // R8: completed pair into a full FIFO raises the sticky overrun flag
  assert_overrun_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.pushRx && rxFull) |=> overrunFlag);
endmodule

// File: rtl/stereo_serial_port.sv
module stereo_serial_port
  import ssp_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int DIV_W      = 8,
  localparam int LVL_W = $clog2(FIFO_DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              fmtMsbJust,
  input  logic              clkSrcExt,
  input  logic [DIV_W-1:0]  divHalf,
  input  logic [LVL_W-1:0]  txThresh,
  input  logic [LVL_W-1:0]  rxThresh,
  input  logic              txWrEn,
  input  logic [PAIR_W-1:0] txWrData,
  output logic              txFull,
  input  logic              rxRdEn,
  output logic [PAIR_W-1:0] rxRdData,
  output logic              rxEmpty,
  output logic              txReq,
  output logic              rxReq,
  output logic              underrunFlag,
  input  logic              clrUnderrun,
  output logic              overrunFlag,
  input  logic              clrOverrun,
  input  logic              extBitClk,
  output logic              bitClk,
  output logic              lrClk,
  output logic              sdOut,
  input  logic              sdIn,
  output logic              sysClkOut
);
  stb_t stb;

  ssp_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .fmtMsbJust(fmtMsbJust),
    .clkSrcExt(clkSrcExt), .divHalf(divHalf), .extBitClk(extBitClk),
    .stb(stb), .bitClkOut(bitClk), .lrClk(lrClk), .sysClkOut(sysClkOut));

  ssp_datapath #(.FIFO_DEPTH(FIFO_DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .enable(enable), .stb(stb),
    .txThresh(txThresh), .rxThresh(rxThresh),
    .txWrEn(txWrEn), .txWrData(txWrData), .txFull(txFull),
    .rxRdEn(rxRdEn), .rxRdData(rxRdData), .rxEmpty(rxEmpty),
    .txReq(txReq), .rxReq(rxReq),
    .underrunFlag(underrunFlag), .clrUnderrun(clrUnderrun),
    .overrunFlag(overrunFlag), .clrOverrun(clrOverrun),
    .sdIn(sdIn), .sdOut(sdOut));
endmodule

// File: tb/stereo_serial_port_tb.sv
module stereo_serial_port_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0, fmtMsbJust = 1'b0, clkSrcExt = 1'b0;
  logic [7:0] divHalf = 8'd1;
  logic [4:0] txThresh = 5'd4, rxThresh = 5'd2;
  logic txWrEn = 1'b0;
  logic [31:0] txWrData = '0;
  logic txFull, rxEmpty, txReq, rxReq, underrunFlag, overrunFlag;
  logic [31:0] rxRdData;
  logic clrUnderrun = 1'b0, clrOverrun = 1'b0;
  logic extBitClk = 1'b0;
  logic bitClk, lrClk, sdOut, sysClkOut;
  logic monRd = 1'b0, manRd = 1'b0;
  logic rxRdEn;
  bit   drainEn = 1'b0, extRun = 1'b0;
  int   checks = 0, errors = 0;
  logic [31:0] expTx[$], expRx[$];

  assign rxRdEn = monRd | manRd;

  always #10 clk = ~clk;  // 50 MHz

  stereo_serial_port u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .fmtMsbJust(fmtMsbJust),
    .clkSrcExt(clkSrcExt), .divHalf(divHalf), .txThresh(txThresh),
    .rxThresh(rxThresh), .txWrEn(txWrEn), .txWrData(txWrData),
    .txFull(txFull), .rxRdEn(rxRdEn), .rxRdData(rxRdData),
    .rxEmpty(rxEmpty), .txReq(txReq), .rxReq(rxReq),
    .underrunFlag(underrunFlag), .clrUnderrun(clrUnderrun),
    .overrunFlag(overrunFlag), .clrOverrun(clrOverrun),
    .extBitClk(extBitClk), .bitClk(bitClk), .lrClk(lrClk),
    .sdOut(sdOut), .sdIn(sdOut), .sysClkOut(sysClkOut));

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // external clock source: half period of four system clocks
  int extCnt = 0;
  always @(posedge clk) begin
    if (extRun) begin
      if (extCnt == 3) begin
        extCnt <= 0;
        extBitClk <= ~extBitClk;
      end else extCnt <= extCnt + 1;
    end
  end

  // pin-level frame decoder, built from the slot rules of R1 and R2
  logic prevBclk = 1'b0, prevLr = 1'b1, started = 1'b0;
  int   kPos = 0, jPos = 0;
  logic [15:0] leftW = '0, rightW = '0;
  logic [31:0] decExp;
  always @(negedge clk) begin
    if (!enable) begin
      started = 1'b0; prevLr = 1'b1; kPos = 0; leftW = '0; rightW = '0;
    end else begin
      if (prevBclk && !bitClk) started = 1'b1;
      if (!prevBclk && bitClk && started) begin
        if (lrClk != prevLr) kPos = 0; else kPos++;
        prevLr = lrClk;
        jPos = kPos - (fmtMsbJust ? 0 : 1);
        if (jPos >= 0 && jPos < 16) begin
          if (!lrClk) leftW[15-jPos] = sdOut;
          else        rightW[15-jPos] = sdOut;
        end
        if (jPos >= 16 && sdOut !== 1'b0)
          check(1'b0, "R1 pad bit", {31'd0, sdOut}, 32'd0);
        if (lrClk && jPos == 15) begin
          decExp = (expTx.size() != 0) ? expTx.pop_front() : 32'd0;
          check({leftW, rightW} == decExp, "R1 R2 R7 pin frame",
                {leftW, rightW}, decExp);
          leftW = '0; rightW = '0;
        end
      end
    end
    prevBclk = bitClk;
  end

  // receive scoreboard monitor (loopback sdOut -> sdIn)
  logic [31:0] rxExp;
  always @(negedge clk) begin
    if (monRd) monRd = 1'b0;
    else if (enable && drainEn && !rxEmpty) begin
      rxExp = (expRx.size() != 0) ? expRx.pop_front() : 32'd0;
      check(rxRdData == rxExp, "R3 R5 rx loopback", rxRdData, rxExp);
      monRd = 1'b1;
    end
  end

  // driver: called at a negedge, writes on consecutive clocks
  task automatic writePairs(input int n, input logic [31:0] base);
    for (int i = 0; i < n; i++) begin
      txWrEn = 1'b1;
      txWrData = base ^ (32'h1357_9BDF * (i + 1));
      if (enable) begin
        expTx.push_back(txWrData);
        expRx.push_back(txWrData);
      end
      @(negedge clk);
    end
    txWrEn = 1'b0;
  endtask

  task automatic measurePeriod(output int per);
    logic p;
    do begin p = bitClk; @(negedge clk); end while (!(!p && bitClk));
    per = 0;
    do begin p = bitClk; @(negedge clk); per++; end while (!(!p && bitClk));
  endtask

  task automatic waitLr(input logic toHigh);
    logic p;
    do begin p = lrClk; @(negedge clk); end while (!(p != toHigh && lrClk == toHigh));
  endtask

  task automatic disableLink();
    enable = 1'b0;
    @(negedge clk);
    expTx.delete(); expRx.delete();
  endtask

  int per;
  logic s1;
  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    check({bitClk, lrClk, sdOut, sysClkOut} == 4'd0, "R9 reset pins",
          {28'd0, bitClk, lrClk, sdOut, sysClkOut}, 32'd0);
    check(rxEmpty && !txReq && !rxReq, "R6 R9 reset status",
          {29'd0, rxEmpty, txReq, rxReq}, 32'd4);
    check(!underrunFlag && !overrunFlag, "R7 R8 reset flags",
          {30'd0, underrunFlag, overrunFlag}, 32'd0);

    // Phase A: standard I2S, internal divider
    drainEn = 1'b1;
    enable = 1'b1;
    writePairs(6, 32'hA5C3_0F81);
    check(!txReq, "R6 tx request above threshold", {31'd0, txReq}, 32'd0);
    check(!rxReq, "R6 rx request empty", {31'd0, rxReq}, 32'd0);
    measurePeriod(per);
    check(per == 4, "R4 internal period", per, 32'd4);
    s1 = sysClkOut; @(negedge clk);
    check(sysClkOut != s1, "R10 sysclk toggles", {31'd0, sysClkOut}, {31'd0, ~s1});
    repeat (9 * 256) @(negedge clk);
    check(expTx.size() == 0 && expRx.size() == 0, "R5 all pairs returned",
          expTx.size() + expRx.size(), 32'd0);
    check(underrunFlag, "R7 underrun sticky", {31'd0, underrunFlag}, 32'd1);
    check(txReq, "R6 tx request at empty", {31'd0, txReq}, 32'd1);
    waitLr(1'b1);
    clrUnderrun = 1'b1; @(negedge clk); clrUnderrun = 1'b0;
    check(!underrunFlag, "R7 underrun clear", {31'd0, underrunFlag}, 32'd0);
    disableLink();
    check({bitClk, lrClk, sdOut, sysClkOut} == 4'd0, "R9 disabled pins",
          {28'd0, bitClk, lrClk, sdOut, sysClkOut}, 32'd0);
    check(rxEmpty && !txReq, "R9 flushed", {30'd0, rxEmpty, txReq}, 32'd2);
    writePairs(1, 32'hDEAD_BEEF);  // ignored while disabled

    // Phase B: MSB-justified
    fmtMsbJust = 1'b1;
    enable = 1'b1;
    writePairs(5, 32'h8001_7FFE);
    repeat (8 * 256) @(negedge clk);
    check(expTx.size() == 0 && expRx.size() == 0, "R2 R5 msb-justified drained",
          expTx.size() + expRx.size(), 32'd0);
    disableLink();

    // Phase C: external bit clock, MSB-justified
    clkSrcExt = 1'b1;
    extRun = 1'b1;
    begin
      logic pe;
      do begin pe = extBitClk; @(negedge clk); end while (!(!pe && extBitClk));
    end
    enable = 1'b1;
    writePairs(4, 32'h0F0F_F0F0);
    measurePeriod(per);
    check(per == 8, "R4 external period", per, 32'd8);
    repeat (7 * 512) @(negedge clk);
    check(expTx.size() == 0 && expRx.size() == 0, "R4 R5 external drained",
          expTx.size() + expRx.size(), 32'd0);

    // Phase D: receive overrun
    drainEn = 1'b0;
    repeat (18 * 512) @(negedge clk);
    check(overrunFlag, "R8 overrun sticky", {31'd0, overrunFlag}, 32'd1);
    check(rxReq, "R6 rx request at threshold", {31'd0, rxReq}, 32'd1);
    waitLr(1'b0);
    begin
      int got = 0;
      for (int i = 0; i < 20; i++) begin
        if (!rxEmpty) begin
          got++;
          manRd = 1'b1; @(negedge clk); manRd = 1'b0;
        end
      end
      check(got == 16, "R8 kept entries", got, 32'd16);
    end
    check(rxEmpty && !rxReq, "R6 R8 drained", {30'd0, rxEmpty, rxReq}, 32'd2);
    clrOverrun = 1'b1; @(negedge clk); clrOverrun = 1'b0;
    check(!overrunFlag, "R8 overrun clear", {31'd0, overrunFlag}, 32'd0);
    disableLink();
    check(sysClkOut == 1'b0, "R10 sysclk idle", {31'd0, sysClkOut}, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule